// File: doc/BRIEF.md
# Window Clip Rectangle Pixel Tester

This block decides, one pixel at a time, whether a pixel at coordinate (X, Y) is drawn. Up to four axis-aligned clip rectangles are held in the block. For each pixel it builds a 4-bit membership code in which each bit marks one rectangle that contains the pixel. It then uses that code to pick one bit of a 16-bit rule mask, and that bit is the pass or fail answer.

The rule mask is not written directly. A control write supplies the number of active rectangles and a mode. In exclude mode a pixel passes only when it lies outside every active rectangle. In include mode a pixel passes only when it lies inside at least one active rectangle. The block derives the mask from these two values and registers it.

Corner writes load one rectangle at a time. The pixel port takes a coordinate qualified by a valid bit. One cycle later it returns a valid-qualified pass flag, together with the membership code that produced it.

Top module: `winclip_tester`

## Requirements
- R1: Rectangle corners are inclusive: a pixel is inside rectangle i when xmin <= X <= xmax and ymin <= Y <= ymax, so pixels on any edge are inside.
- R2: Bit i of `res_code` (bit 0 for rectangle 0, bit 3 for rectangle 3) is 1 exactly when the pixel lies inside active rectangle i.
- R3: `res_pass` equals bit number `res_code` of the derived 16-bit rule mask.
- R4: With an active count of 0 the mask is all ones, so every pixel passes and `res_code` is 0.
- R5: In exclude mode (`cfg_include` = 0) with n active rectangles, the mask bit for code c is 1 exactly when the low n bits of c are all zero. A pixel therefore passes only when it is outside all active rectangles.
- R6: In include mode (`cfg_include` = 1) with n >= 1 active rectangles, the mask is the bitwise inverse of the exclude-mode mask for the same n. A pixel therefore passes only when it is inside at least one active rectangle.
- R7: A `cfg_count` value above 4 is stored as 4.
- R8: `res_valid` is high in exactly the cycle after a cycle in which `pix_valid` is high. `res_pass` and `res_code` belong to that pixel.
- R9: A configuration write takes effect for pixels presented in later cycles. A pixel presented in the same cycle as the write is tested against the previous configuration.
- R10: A rectangle whose min exceeds its max on either axis contains no pixels.
- R11: Rectangles with index at or above the active count are ignored, and their code bits are 0.
- R12: After reset the active count is 0, the mode is exclude and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rect_we | input | 1 | Write corners of one rectangle |
| cfg_rect_idx | input | 2 | Rectangle being written |
| cfg_xmin | input | 15 | Left edge, inclusive |
| cfg_ymin | input | 15 | Top edge, inclusive |
| cfg_xmax | input | 15 | Right edge, inclusive |
| cfg_ymax | input | 15 | Bottom edge, inclusive |
| cfg_ctl_we | input | 1 | Write active count and mode |
| cfg_count | input | 3 | Number of active rectangles |
| cfg_include | input | 1 | 1 = include mode, 0 = exclude mode |
| pix_valid | input | 1 | Pixel coordinate valid |
| pix_x | input | 15 | Pixel X |
| pix_y | input | 15 | Pixel Y |
| res_valid | output | 1 | Result valid |
| res_pass | output | 1 | Pixel is rasterized |
| res_code | output | 4 | Membership code of the pixel |

## Verification
The checker's properties compare each result against the registered mask and the active count. This only works if neither changed at the edge where the result was captured, so those properties are guarded by `$stable` on that state. They also assume the reset pulse lasts a full clock, so that no pixel is in flight when reset releases. The stimulus holds reset for several cycles with `pix_valid` low. It issues each write and each pixel on the falling edge, so every input is settled well before the rising edge. The bench deliberately places a control write in the same cycle as a pixel, which exercises the old-configuration rule that the guarded properties step around.

// File: rtl/winclip_pkg.sv
package winclip_pkg;

    parameter int COORD_W  = 15;
    parameter int NUM_RECT = 4;

    localparam int IDX_W  = $clog2(NUM_RECT);
    localparam int CNT_W  = $clog2(NUM_RECT + 1);
    localparam int RULE_W = 1 << NUM_RECT;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [NUM_RECT-1:0] code_t;
    typedef logic [RULE_W-1:0]  rule_t;
    typedef logic [CNT_W-1:0]   count_t;

    typedef enum logic {
        MODE_EXCLUDE = 1'b0,
        MODE_INCLUDE = 1'b1
    } clip_mode_e;

    typedef struct packed {
        coord_t xlo;
        coord_t ylo;
        coord_t xhi;
        coord_t yhi;
    } rect_t;

    typedef struct packed {
        logic   valid;
        coord_t x;
        coord_t y;
    } pixel_t;

    function automatic count_t clamp_count(input count_t n);
        return (n > count_t'(NUM_RECT)) ? count_t'(NUM_RECT) : n;
    endfunction

    // Mask bit c is set when no active rectangle holds the pixel (exclude),
    // inverted for include; zero active rectangles accepts every code.
    function automatic rule_t build_rule(input count_t n, input clip_mode_e mode);
        rule_t excl;
        code_t act;
        excl = '0;
        act  = '0;
        for (int i = 0; i < NUM_RECT; i++) begin
            act[i] = (count_t'(i) < n);
        end
        for (int c = 0; c < RULE_W; c++) begin
            excl[c] = ((code_t'(c) & act) == '0);
        end
        if (n == '0) begin
            return '1;
        end
        return (mode == MODE_INCLUDE) ? ~excl : excl;
    endfunction

endpackage

// File: rtl/winclip_cfg.sv
module winclip_cfg
    import winclip_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rect_we,
    input  logic [IDX_W-1:0]     rect_idx,
    input  rect_t                rect_wdata,
    input  logic                 ctl_we,
    input  count_t               ctl_count,
    input  clip_mode_e           ctl_mode,
    output rect_t [NUM_RECT-1:0] rects,
    output count_t               count,
    output clip_mode_e           mode,
    output rule_t                rule
);

    rect_t [NUM_RECT-1:0] rects_q;
    count_t               count_q;
    clip_mode_e           mode_q;
    rule_t                rule_q;
    count_t               count_c;

    assign count_c = clamp_count(ctl_count);

    for (genvar g = 0; g < NUM_RECT; g++) begin : g_rect
        always_ff @(posedge clk) begin
            if (rst) begin
                rects_q[g] <= '0;
            end else if (rect_we && rect_idx == IDX_W'(g)) begin
                rects_q[g] <= rect_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            mode_q  <= MODE_EXCLUDE;
            rule_q  <= '1;
        end else if (ctl_we) begin
            count_q <= count_c;
            mode_q  <= ctl_mode;
            rule_q  <= build_rule(count_c, ctl_mode);
        end
    end

    assign rects = rects_q;
    assign count = count_q;
    assign mode  = mode_q;
    assign rule  = rule_q;

endmodule

// File: rtl/winclip_rect_match.sv
module winclip_rect_match
    import winclip_pkg::*;
(
    input  rect_t  rect,
    input  logic   enable,
    input  coord_t x,
    input  coord_t y,
    output logic   hit
);

    logic in_x;
    logic in_y;

    always_comb begin
        in_x = (x >= rect.xlo) && (x <= rect.xhi);
        in_y = (y >= rect.ylo) && (y <= rect.yhi);
        hit  = enable && in_x && in_y;
    end

endmodule

// File: rtl/winclip_decide.sv
module winclip_decide
    import winclip_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  code_t in_code,
    input  rule_t rule,
    output logic  out_valid,
    output logic  out_pass,
    output code_t out_code
);

    logic  valid_q;
    logic  pass_q;
    code_t code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            pass_q  <= 1'b0;
            code_q  <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                pass_q <= rule[in_code];
                code_q <= in_code;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_pass  = pass_q;
    assign out_code  = code_q;

endmodule

// File: rtl/winclip_tester.sv
module winclip_tester
    import winclip_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_rect_we,
    input  logic [1:0]  cfg_rect_idx,
    input  logic [14:0] cfg_xmin,
    input  logic [14:0] cfg_ymin,
    input  logic [14:0] cfg_xmax,
    input  logic [14:0] cfg_ymax,
    input  logic        cfg_ctl_we,
    input  logic [2:0]  cfg_count,
    input  logic        cfg_include,
    input  logic        pix_valid,
    input  logic [14:0] pix_x,
    input  logic [14:0] pix_y,
    output logic        res_valid,
    output logic        res_pass,
    output logic [3:0]  res_code
);

    rect_t                wdata;
    rect_t [NUM_RECT-1:0] rects;
    count_t               count_q;
    clip_mode_e           mode_q;
    rule_t                rule_q;
    pixel_t               pix;
    code_t                hits;
    code_t                code_o;

    assign wdata = '{xlo: cfg_xmin, ylo: cfg_ymin, xhi: cfg_xmax, yhi: cfg_ymax};
    assign pix   = '{valid: pix_valid, x: pix_x, y: pix_y};

    winclip_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .rect_we    (cfg_rect_we),
        .rect_idx   (IDX_W'(cfg_rect_idx)),
        .rect_wdata (wdata),
        .ctl_we     (cfg_ctl_we),
        .ctl_count  (count_t'(cfg_count)),
        .ctl_mode   (clip_mode_e'(cfg_include)),
        .rects      (rects),
        .count      (count_q),
        .mode       (mode_q),
        .rule       (rule_q)
    );

    for (genvar g = 0; g < NUM_RECT; g++) begin : g_match
        winclip_rect_match u_match (
            .rect   (rects[g]),
            .enable (count_t'(g) < count_q),
            .x      (pix.x),
            .y      (pix.y),
            .hit    (hits[g])
        );
    end

    winclip_decide u_decide (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (pix.valid),
        .in_code   (hits),
        .rule      (rule_q),
        .out_valid (res_valid),
        .out_pass  (res_pass),
        .out_code  (code_o)
    );

    assign res_code = 4'(code_o);

endmodule

// File: rtl/winclip_tester_chk.sv
module winclip_tester_chk
    import winclip_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       pix_valid,
    input logic       res_valid,
    input logic       res_pass,
    input logic [3:0] res_code,
    input count_t     act_count,
    input rule_t      rule
);

    // R8: result valid follows pixel valid by one cycle
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> res_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !res_valid);

    // R3: pass flag is the mask bit selected by the code
    a_r3_rule_select: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $stable(rule)) |-> (res_pass == rule[res_code]));

    // R11: inactive rectangles never set code bits
    a_r11_inactive_zero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $stable(act_count)) |-> ((res_code >> act_count) == 4'd0));

    // R4: zero active rectangles pass every pixel
    a_r4_empty_passes: assert property (@(posedge clk) disable iff (rst)
        (res_valid && act_count == '0 && $stable(act_count)) |-> res_pass);

    // R7: stored count never exceeds the rectangle total
    a_r7_count_cap: assert property (@(posedge clk) disable iff (rst)
        act_count <= count_t'(NUM_RECT));

endmodule

bind winclip_tester winclip_tester_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .res_valid (res_valid),
    .res_pass  (res_pass),
    .res_code  (res_code),
    .act_count (count_q),
    .rule      (rule_q)
);

// File: tb/winclip_tester_bench.sv
module winclip_tester_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_rect_we = 1'b0;
    logic [1:0]  cfg_rect_idx = '0;
    logic [14:0] cfg_xmin = '0, cfg_ymin = '0, cfg_xmax = '0, cfg_ymax = '0;
    logic        cfg_ctl_we = 1'b0;
    logic [2:0]  cfg_count = '0;
    logic        cfg_include = 1'b0;
    logic        pix_valid = 1'b0;
    logic [14:0] pix_x = '0, pix_y = '0;
    logic        res_valid, res_pass;
    logic [3:0]  res_code;

    always #2 clk = ~clk;

    winclip_tester u_winclip_tester (.*);

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // model state
    int m_xl[4], m_yl[4], m_xh[4], m_yh[4];
    int m_cnt = 0;
    bit m_inc = 0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    function automatic logic [4:0] expect_of(input int x, input int y);
        logic [3:0] c;
        logic p;
        c = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < m_cnt && x >= m_xl[i] && x <= m_xh[i] && y >= m_yl[i] && y <= m_yh[i])
                c[i] = 1'b1;
        end
        if (m_cnt == 0) p = 1'b1;
        else if (m_inc) p = (c != 4'd0);
        else p = (c == 4'd0);
        return {p, c};
    endfunction

    task automatic idle();
        @(negedge clk);
        pix_valid = 0; cfg_rect_we = 0; cfg_ctl_we = 0;
    endtask

    task automatic put_rect(input int idx, input int xl, input int yl, input int xh, input int yh);
        @(negedge clk);
        pix_valid = 0; cfg_ctl_we = 0;
        cfg_rect_we = 1; cfg_rect_idx = 2'(idx);
        cfg_xmin = 15'(xl); cfg_ymin = 15'(yl); cfg_xmax = 15'(xh); cfg_ymax = 15'(yh);
        m_xl[idx] = xl; m_yl[idx] = yl; m_xh[idx] = xh; m_yh[idx] = yh;
    endtask

    // optional pixel in the same cycle as a control write
    task automatic put_ctl(input int n, input bit inc, input bit with_pix,
                           input int x, input int y, input string tag);
        @(negedge clk);
        cfg_rect_we = 0;
        cfg_ctl_we = 1; cfg_count = 3'(n); cfg_include = inc;
        pix_valid = with_pix; pix_x = 15'(x); pix_y = 15'(y);
        if (with_pix) begin
            exp_q.push_back(expect_of(x, y));
            tag_q.push_back(tag);
        end
        m_cnt = (n > 4) ? 4 : n;
        m_inc = inc;
    endtask

    task automatic pixel(input int x, input int y, input string tag);
        @(negedge clk);
        cfg_rect_we = 0; cfg_ctl_we = 0;
        pix_valid = 1; pix_x = 15'(x); pix_y = 15'(y);
        exp_q.push_back(expect_of(x, y));
        tag_q.push_back(tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R8: result with no pixel pending, got pass=%0b code=%0h", res_pass, res_code);
            end else begin
                logic [4:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({res_pass, res_code} !== e) begin
                    fails++;
                    $display("FAIL %s: pass=%0b code=%0h expected pass=%0b code=%0h",
                             t, res_pass, res_code, e[4], e[3:0]);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: run hung, got cycles=%0d expected < 5000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        tests++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R12: res_valid=%0b expected 0", res_valid);
        end
        pixel(5, 5, "R12 reset count zero");
        pixel(30000, 1, "R4 zero count passes");

        put_rect(0, 10, 10, 20, 20);
        put_rect(1, 15, 15, 30, 30);
        put_rect(2, 100, 0, 110, 5);
        put_rect(3, 50, 0, 40, 10);

        // R9: control write and pixel in one cycle uses old config
        put_ctl(1, 0, 1, 12, 12, "R9 same-cycle old config");
        pixel(12, 12, "R9 next pixel new config");
        // R1 inclusive edges
        pixel(10, 10, "R1 top-left corner");
        pixel(20, 20, "R1 bottom-right corner");
        pixel(21, 20, "R1 just right of edge");
        pixel(9, 10, "R1 just left of edge");
        // R5 exclude with two rectangles
        put_ctl(2, 0, 0, 0, 0, "");
        pixel(16, 16, "R2 R5 inside both");
        pixel(25, 25, "R5 inside rect 1 only");
        pixel(5, 5, "R5 outside all");
        // R6 include
        put_ctl(2, 1, 0, 0, 0, "");
        pixel(25, 25, "R6 inside one");
        pixel(5, 5, "R6 outside all");
        pixel(105, 3, "R11 rect 2 inactive");
        put_ctl(3, 1, 0, 0, 0, "");
        pixel(105, 3, "R2 R6 rect 2 active");
        // R10 inverted rectangle with four active
        put_ctl(4, 0, 0, 0, 0, "");
        pixel(45, 5, "R10 inverted rect empty");
        pixel(50, 5, "R10 inverted rect edge");
        pixel(16, 16, "R5 four active inside");
        // R7 count above four
        put_ctl(7, 1, 0, 0, 0, "");
        pixel(16, 16, "R7 clamped include inside");
        pixel(1, 1, "R7 clamped include outside");
        pixel(105, 5, "R7 rect 2 edge active");
        // back to zero in include mode
        put_ctl(0, 1, 0, 0, 0, "");
        pixel(16, 16, "R4 zero count include");
        // coordinate extremes; rect write with a pixel right after
        put_rect(0, 32767, 32767, 32767, 32767);
        put_ctl(1, 1, 0, 0, 0, "");
        pixel(32767, 32767, "R1 max coordinate inside");
        pixel(32766, 32767, "R1 max coordinate outside");
        pixel(0, 0, "R6 origin outside");
        idle();
        repeat (4) @(negedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R8: %0d results missing expected 0", exp_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule